// File: doc/BRIEF.md
# Memory Error Capture Register File

This block sits beside a memory controller's ECC checker and keeps a record of corrected (single-bit) and uncorrectable (multi-bit) error events for software. Each kind of event arrives as a one-cycle strobe with the full 32-bit physical address and the 3-bit DRAM row index. The block keeps only the first event of each kind. It stores the 4 KB page of the faulting location, a sticky flag per kind, and the row of the first event of each kind. Software reads and clears this record through a byte-addressed register port.

Clearing a flag re-arms capture for that kind. A set of per-kind enable bits decides which held flags drive the system-error output. The error strobes are plain status inputs with no valid/ready pair. The block accepts an event in every cycle and never applies back-pressure, so a strobe that arrives while its kind is already flagged is dropped by design.

Register map (byte offsets). Offsets 0x00 to 0x03 hold the 32-bit error-address word, least significant byte at 0x00. Offsets 0x04 and 0x05 hold the 16-bit status word. Offset 0x06 holds the 8-bit command byte. Reads take effect in the same cycle. Writes take effect at the next rising clock edge.

Top module: `memerr_capture_regs`

## Requirements
- R1: After reset, every register byte reads 0x00 and `serr_o` is 0.
- R2: A single-bit strobe with the single-bit flag clear sets the flag, which reads as bit 0 of the error-address word and bit 0 of the status word. The same strobe stores the row in status bits 3:1 and address bits 31:12 in error-address bits 31:12, unless R6 says otherwise. Error-address bits 11:2 always read 0.
- R3: A multi-bit strobe with the multi-bit flag clear sets the flag, which reads as error-address bit 1 and status bit 4. The same strobe stores the row in status bits 7:5 and address bits 31:12 in error-address bits 31:12.
- R4: While a flag is set and not being cleared, further strobes of the same kind change neither its row field nor the captured page.
- R5: When both kinds strike in the same cycle with both flags clear, both flags and both rows are captured, and the page comes from the multi-bit address.
- R6: A multi-bit capture replaces a page held from a single-bit error. A single-bit capture does not change the page while the multi-bit flag stays set.
- R7: Writing 1 clears a flag, through either byte 0x00 (bit 0 single-bit, bit 1 multi-bit) or byte 0x04 (bit 0 single-bit, bit 4 multi-bit). Writing 0 to those bits, or any value to the other bits, leaves the flag unchanged. Clearing leaves the row field as it was and re-arms capture.
- R8: If a clear and a new strobe of the same kind fall in one cycle, the flag stays set and the new row and page are captured.
- R9: Command byte 0x06 bit 1 enables system error on multi-bit errors and bit 0 enables it on single-bit errors. Its bits 7:2 read 0.
- R10: `serr_o` is 1 exactly when a set flag has its enable bit set. It follows flag and enable changes one clock edge after the strobe or write.
- R11: Byte 0x05 and every offset above 0x06 read 0x00. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sbe_strobe_i | input | 1 | Single-bit error event, one cycle |
| sbe_addr_i | input | 32 | Address of the single-bit error |
| sbe_row_i | input | 3 | DRAM row of the single-bit error |
| mbe_strobe_i | input | 1 | Multi-bit error event, one cycle |
| mbe_addr_i | input | 32 | Address of the multi-bit error |
| mbe_row_i | input | 3 | DRAM row of the multi-bit error |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe for `reg_wdata_i` at `reg_addr_i` |
| reg_wdata_i | input | 8 | Write data byte |
| reg_rdata_o | output | 8 | Read data byte at `reg_addr_i` |
| serr_o | output | 1 | System-error signal |

## Verification
Two things can land in the same cycle: a software write-one-to-clear of a flag and a new strobe of the same kind. A second coincidence is a single-bit and a multi-bit strobe arriving together. The vector table drives a byte-0x00 clear together with a multi-bit strobe, then a clear together with a single-bit strobe. It judges both cases by the flag staying set and the row and page being replaced by the new event. The coincident-strobe case is judged by both flags and rows being captured and the page coming from the multi-bit address.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
  // Byte offsets of the register file
  localparam logic [7:0] OFS_EADDR = 8'h00;  // 4 bytes, LSB first
  localparam logic [7:0] OFS_STAT  = 8'h04;  // 2 bytes
  localparam logic [7:0] OFS_CMD   = 8'h06;  // 1 byte

  // Bit positions decoded by software
  localparam int EA_SBE_BIT   = 0;
  localparam int EA_MBE_BIT   = 1;
  localparam int ST_SBE_BIT   = 0;
  localparam int ST_MBE_BIT   = 4;
  localparam int CMD_SBE_BIT  = 0;
  localparam int CMD_MBE_BIT  = 1;

  localparam int NKIND = 2;
  typedef enum int {KIND_SBE = 0, KIND_MBE = 1} err_kind_e;
endpackage

// File: rtl/memerr_flag_slot.sv
module memerr_flag_slot #(
  parameter int ROW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             clr_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             flag_o,
  output logic [ROW_W-1:0] row_o,
  output logic             armed_o,
  output logic             take_o
);
  logic             flag_q;
  logic [ROW_W-1:0] row_q;

  // A clear in this cycle re-arms capture; a new event beats the clear.
  assign armed_o = ~flag_q | clr_i;
  assign take_o  = evt_i & armed_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      row_q  <= '0;
    end else begin
      if (take_o)     flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
      if (take_o)     row_q  <= row_i;
    end
  end

  assign flag_o = flag_q;
  assign row_o  = row_q;

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> flag_q);
  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !evt_i |=> !flag_q);
  assert_first_row_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_i |=> row_q == $past(row_q));
  assert_race_recaptures_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && evt_i |=> flag_q && row_q == $past(row_i));
endmodule

// File: rtl/memerr_page_hold.sv
module memerr_page_hold #(
  parameter int ERR_AW   = 32,
  parameter int PAGE_LSB = 12,
  localparam int PAGE_W  = ERR_AW - PAGE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_mbe_i,
  input  logic              take_sbe_i,
  input  logic [ERR_AW-1:0] mbe_addr_i,
  input  logic [ERR_AW-1:0] sbe_addr_i,
  output logic [PAGE_W-1:0] page_o
);
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          page_q <= '0;
    else if (take_mbe_i) page_q <= mbe_addr_i[ERR_AW-1:PAGE_LSB];
    else if (take_sbe_i) page_q <= sbe_addr_i[ERR_AW-1:PAGE_LSB];
  end

  assign page_o = page_q;

  assert_mbe_page_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_mbe_i |=> page_q == $past(mbe_addr_i[ERR_AW-1:PAGE_LSB]));
  assert_idle_page_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !take_mbe_i && !take_sbe_i |=> $stable(page_q));
endmodule

// File: rtl/memerr_read_mux.sv
module memerr_read_mux #(
  parameter int ERR_AW   = 32,
  parameter int PAGE_LSB = 12,
  parameter int ROW_W    = 3,
  parameter int REG_AW   = 8,
  localparam int PAGE_W  = ERR_AW - PAGE_LSB,
  localparam int EA_BYTES = ERR_AW / 8
) (
  input  logic [REG_AW-1:0] rd_addr_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              sbe_flag_i,
  input  logic              mbe_flag_i,
  input  logic [ROW_W-1:0]  sbe_row_i,
  input  logic [ROW_W-1:0]  mbe_row_i,
  input  logic [1:0]        cmd_i,
  output logic [7:0]        rdata_o
);
  import memerr_pkg::*;

  logic [ERR_AW-1:0] eaddr_w;
  logic [15:0]       stat_w;

  always_comb begin
    eaddr_w = '0;
    eaddr_w[ERR_AW-1:PAGE_LSB] = page_i;
    eaddr_w[EA_SBE_BIT] = sbe_flag_i;
    eaddr_w[EA_MBE_BIT] = mbe_flag_i;
    stat_w = '0;
    stat_w[ST_SBE_BIT]                 = sbe_flag_i;
    stat_w[ST_SBE_BIT+1 +: ROW_W]      = sbe_row_i;
    stat_w[ST_MBE_BIT]                 = mbe_flag_i;
    stat_w[ST_MBE_BIT+1 +: ROW_W]      = mbe_row_i;
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int b = 0; b < EA_BYTES; b++) begin
      if (rd_addr_i == REG_AW'(OFS_EADDR) + REG_AW'(b))
        rdata_o = eaddr_w[8*b +: 8];
    end
    if (rd_addr_i == REG_AW'(OFS_STAT))           rdata_o = stat_w[7:0];
    if (rd_addr_i == REG_AW'(OFS_STAT) + 1'b1)    rdata_o = stat_w[15:8];
    if (rd_addr_i == REG_AW'(OFS_CMD))            rdata_o = {6'b0, cmd_i};
  end
endmodule

// File: rtl/memerr_capture_regs.sv
module memerr_capture_regs #(
  parameter int ERR_AW   = 32,
  parameter int PAGE_LSB = 12,
  parameter int ROW_W    = 3,
  parameter int REG_AW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sbe_strobe_i,
  input  logic [ERR_AW-1:0] sbe_addr_i,
  input  logic [ROW_W-1:0]  sbe_row_i,
  input  logic              mbe_strobe_i,
  input  logic [ERR_AW-1:0] mbe_addr_i,
  input  logic [ROW_W-1:0]  mbe_row_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              serr_o
);
  import memerr_pkg::*;

  localparam int PAGE_W = ERR_AW - PAGE_LSB;

  logic [NKIND-1:0]            evt, clr, flag, armed, take;
  logic [NKIND-1:0][ROW_W-1:0] row_in, row_q;
  logic [1:0]                  cmd_q;
  logic [PAGE_W-1:0]           page;
  logic                        wr_ea, wr_st, wr_cmd;

  assign wr_ea  = reg_wr_i && reg_addr_i == REG_AW'(OFS_EADDR);
  assign wr_st  = reg_wr_i && reg_addr_i == REG_AW'(OFS_STAT);
  assign wr_cmd = reg_wr_i && reg_addr_i == REG_AW'(OFS_CMD);

  assign evt[KIND_SBE]    = sbe_strobe_i;
  assign evt[KIND_MBE]    = mbe_strobe_i;
  assign row_in[KIND_SBE] = sbe_row_i;
  assign row_in[KIND_MBE] = mbe_row_i;
  assign clr[KIND_SBE] = (wr_ea & reg_wdata_i[EA_SBE_BIT]) | (wr_st & reg_wdata_i[ST_SBE_BIT]);
  assign clr[KIND_MBE] = (wr_ea & reg_wdata_i[EA_MBE_BIT]) | (wr_st & reg_wdata_i[ST_MBE_BIT]);

  for (genvar k = 0; k < NKIND; k++) begin : g_slot
    memerr_flag_slot #(.ROW_W(ROW_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .evt_i(evt[k]), .clr_i(clr[k]),
      .row_i(row_in[k]), .flag_o(flag[k]), .row_o(row_q[k]),
      .armed_o(armed[k]), .take_o(take[k])
    );
  end

  // A single-bit page only lands if no multi-bit page is held or arriving.
  memerr_page_hold #(.ERR_AW(ERR_AW), .PAGE_LSB(PAGE_LSB)) u_page (
    .clk(clk), .rst_n(rst_n),
    .take_mbe_i(take[KIND_MBE]),
    .take_sbe_i(take[KIND_SBE] & armed[KIND_MBE] & ~evt[KIND_MBE]),
    .mbe_addr_i(mbe_addr_i), .sbe_addr_i(sbe_addr_i), .page_o(page)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= 2'b00;
    else if (wr_cmd) cmd_q <= {reg_wdata_i[CMD_MBE_BIT], reg_wdata_i[CMD_SBE_BIT]};
  end

  assign serr_o = (flag[KIND_MBE] & cmd_q[1]) | (flag[KIND_SBE] & cmd_q[0]);

  memerr_read_mux #(.ERR_AW(ERR_AW), .PAGE_LSB(PAGE_LSB), .ROW_W(ROW_W), .REG_AW(REG_AW)) u_rd (
    .rd_addr_i(reg_addr_i), .page_i(page),
    .sbe_flag_i(flag[KIND_SBE]), .mbe_flag_i(flag[KIND_MBE]),
    .sbe_row_i(row_q[KIND_SBE]), .mbe_row_i(row_q[KIND_MBE]),
    .cmd_i(cmd_q), .rdata_o(reg_rdata_o)
  );

  assert_reset_clean_R1: assert property (@(posedge clk)
    !rst_n |=> flag == '0 && cmd_q == 2'b00 && !serr_o);
  assert_no_serr_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q == 2'b00 |-> !serr_o);
  assert_sbe_keeps_mbe_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag[KIND_MBE] && !clr[KIND_MBE] && !mbe_strobe_i |=> $stable(page));
endmodule

// File: tb/memerr_capture_regs_tb.sv
`timescale 1ns/1ps
module memerr_capture_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sbe_strobe, mbe_strobe, reg_wr, serr;
  logic [31:0] sbe_addr, mbe_addr;
  logic [2:0]  sbe_row, mbe_row;
  logic [7:0]  reg_addr, reg_wdata, reg_rdata;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  memerr_capture_regs u_dut (
    .clk(clk), .rst_n(rst_n),
    .sbe_strobe_i(sbe_strobe), .sbe_addr_i(sbe_addr), .sbe_row_i(sbe_row),
    .mbe_strobe_i(mbe_strobe), .mbe_addr_i(mbe_addr), .mbe_row_i(mbe_row),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .serr_o(serr)
  );

  typedef struct packed {
    logic        sbe;   logic        mbe;
    logic [2:0]  srow;  logic [2:0]  mrow;
    logic [31:0] saddr; logic [31:0] maddr;
    logic        wr;    logic [7:0]  wa;    logic [7:0] wd;
    logic [31:0] ea;    logic [7:0]  es;    logic       eserr;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,3'd0,3'd0,32'h0,32'h0,1'b1,8'h06,8'h03,32'h00000000,8'h00,1'b0},        // R9 enable both
    '{1'b1,1'b0,3'd5,3'd0,32'h12345678,32'h0,1'b0,8'h00,8'h00,32'h12345001,8'h0B,1'b1}, // R2 R10
    '{1'b1,1'b0,3'd2,3'd0,32'hAAAAA000,32'h0,1'b0,8'h00,8'h00,32'h12345001,8'h0B,1'b1}, // R4
    '{1'b0,1'b1,3'd0,3'd6,32'h0,32'h87654321,1'b0,8'h00,8'h00,32'h87654003,8'hDB,1'b1}, // R3 R6
    '{1'b1,1'b1,3'd1,3'd3,32'h11111111,32'h22222222,1'b0,8'h00,8'h00,32'h87654003,8'hDB,1'b1}, // R4
    '{1'b0,1'b0,3'd0,3'd0,32'h0,32'h0,1'b1,8'h00,8'h01,32'h87654002,8'hDA,1'b1},        // R7 byte 0
    '{1'b1,1'b0,3'd4,3'd0,32'h55555000,32'h0,1'b0,8'h00,8'h00,32'h87654003,8'hD9,1'b1}, // R6
    '{1'b0,1'b0,3'd0,3'd0,32'h0,32'h0,1'b1,8'h04,8'h10,32'h87654001,8'hC9,1'b1},        // R7 byte 4
    '{1'b0,1'b0,3'd0,3'd0,32'h0,32'h0,1'b1,8'h06,8'h02,32'h87654001,8'hC9,1'b0},        // R10 mask
    '{1'b0,1'b0,3'd0,3'd0,32'h0,32'h0,1'b1,8'h00,8'h01,32'h87654000,8'hC8,1'b0},        // R7
    '{1'b1,1'b1,3'd7,3'd1,32'h00003FFF,32'hFFFFF123,1'b0,8'h00,8'h00,32'hFFFFF003,8'h3F,1'b1}, // R5
    '{1'b0,1'b1,3'd0,3'd2,32'h0,32'h0ABCD000,1'b1,8'h00,8'h02,32'h0ABCD003,8'h5F,1'b1}, // R8 mbe
    '{1'b0,1'b0,3'd0,3'd0,32'h0,32'h0,1'b1,8'h04,8'h11,32'h0ABCD000,8'h4E,1'b0},        // R7 both
    '{1'b1,1'b0,3'd3,3'd0,32'h00001000,32'h0,1'b0,8'h00,8'h00,32'h00001001,8'h47,1'b0}, // R2 R10
    '{1'b0,1'b0,3'd0,3'd0,32'h0,32'h0,1'b1,8'h00,8'hFC,32'h00001001,8'h47,1'b0},        // R7 zero bits
    '{1'b1,1'b0,3'd6,3'd0,32'h00CAF000,32'h0,1'b1,8'h00,8'h01,32'h00CAF001,8'h4D,1'b0}  // R8 sbe
  };

  task automatic check8(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.2;
    d = reg_rdata;
  endtask

  task automatic read_regs(output logic [31:0] ea, output logic [15:0] st);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(8'(i), b);
      ea[8*i +: 8] = b;
    end
    rd(8'h04, b); st[7:0] = b;
    rd(8'h05, b); st[15:8] = b;
  endtask

  task automatic idle_inputs();
    sbe_strobe = 1'b0; mbe_strobe = 1'b0; reg_wr = 1'b0;
    sbe_addr = '0; mbe_addr = '0; sbe_row = '0; mbe_row = '0;
    reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    logic [31:0] ea;
    logic [15:0] st;
    logic [7:0]  b;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1: reset state, checked while in reset and just after release
    read_regs(ea, st);
    check8("R1 eaddr in reset", ea, 32'h0);
    check8("R1 status in reset", {16'h0, st}, 32'h0);
    check8("R1 serr in reset", {31'h0, serr}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h06, b);
    check8("R1 cmd after reset", {24'h0, b}, 32'h0);

    // R9: reserved command bits read 0
    wr_byte(8'h06, 8'hFF);
    rd(8'h06, b);
    check8("R9 cmd readback", {24'h0, b}, 32'h3);
    // R11: unmapped writes ignored, unmapped reads zero
    wr_byte(8'h20, 8'hFF);
    rd(8'h20, b);
    check8("R11 unmapped 0x20", {24'h0, b}, 32'h0);
    rd(8'h07, b);
    check8("R11 unmapped 0x07", {24'h0, b}, 32'h0);
    wr_byte(8'h06, 8'h00);

    // Vector table walk: inputs set at a negedge, results read at the next negedge
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      sbe_strobe = VEC[v].sbe;  sbe_row = VEC[v].srow; sbe_addr = VEC[v].saddr;
      mbe_strobe = VEC[v].mbe;  mbe_row = VEC[v].mrow; mbe_addr = VEC[v].maddr;
      reg_wr = VEC[v].wr; reg_addr = VEC[v].wa; reg_wdata = VEC[v].wd;
      @(negedge clk);
      idle_inputs();
      read_regs(ea, st);
      check8($sformatf("vec %0d eaddr (R2 R3 R4 R5 R6 R8)", v), ea, VEC[v].ea);
      check8($sformatf("vec %0d status (R2 R3 R7 R11)", v), {16'h0, st}, {24'h0, VEC[v].es});
      check8($sformatf("vec %0d serr (R10)", v), {31'h0, serr}, {31'h0, VEC[v].eserr});
    end

    // R1: reset in mid-run clears the held record
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_regs(ea, st);
    check8("R1 eaddr after mid reset", ea, 32'h0);
    check8("R1 status after mid reset", {16'h0, st}, 32'h0);
    check8("R1 serr after mid reset", {31'h0, serr}, 32'h0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule